// File: doc/BRIEF.md
# Low-Power Stop Mode Controller

This controller moves a small device between normal operation and two stop levels. The first is a retention stop, in which every register, the RAM and the pins keep their values and the regulator drops to standby. The second is a deep stop, in which the regulator is switched off and the powered-down domains are held in reset. A stop request and a level select come from the processor. Waking is driven by the reset pin, by a supply-low detector, and by a set of per-source interrupt lines that each have an enable. On every exit the controller reports whether the processor should take the reset vector or an interrupt vector, and for an interrupt it reports which source.

Leaving deep stop always goes through a system reset. The always-on real-time timer domain has its own reset, which only the supply detector asserts, so a timer interrupt that caused the wake stays pending in that domain. After the reset the controller enters a recovery phase. A sticky status flag is raised and the pin hold latches stay closed until software writes a one to the acknowledge input. Software uses this window to restore the port and peripheral settings before the pins are released.

Top module: `pwr_stop_ctrl`

## Requirements
- R1: While rst_n is low, sys_rst_o, domain_rst_o and rtc_rst_o are 1, wake_flag_o and io_hold_o are 0 and reg_mode_o is 2'b00, even if rst_n falls during recovery. In the first cycle after release the controller enters run and pulses vec_take_o with vec_is_reset_o=1.
- R2: While lvd_i is 1, in any state, sys_rst_o, domain_rst_o and rtc_rst_o are 1 from the next cycle. When lvd_i clears, a reset vector is reported (vec_take_o=1, vec_is_reset_o=1).
- R3: A stop_req_i with deep_sel_i=0 and no enabled pending line enters retention stop. There reg_mode_o=2'b01 (standby), and sys_rst_o, domain_rst_o and io_hold_o are all 0.
- R4: Retention stop exits to run on any line with irq_i and irq_en_i both set. Lines are indexed 0 timer, 1 converter, 2 external IRQ, 3 serial, 4 keyboard. vec_take_o pulses with vec_is_reset_o=0 and vec_src_o set to the lowest pending index. A disabled line does not wake.
- R5: The reset pin (rst_pin_i=1) exits retention stop into system reset for as long as it is held. On release the controller returns to run with a reset vector.
- R6: A stop_req_i with deep_sel_i=1 enters deep stop. There reg_mode_o=2'b10 (off), domain_rst_o=1 and io_hold_o=1, while sys_rst_o=0 and rtc_rst_o=0.
- R7: In deep stop only rst_pin_i, lvd_i or an enabled timer line (index 0) cause an exit. Every other line is ignored, and so is a disabled timer line.
- R8: A deep stop exit gives one or more cycles of system reset with rtc_rst_o kept at 0, then recovery. In recovery wake_flag_o=1, io_hold_o=1 and a reset vector is reported.
- R9: wake_flag_o and io_hold_o stay at 1 until ack_wr_i=1 with ack_data_i=1 in recovery; the controller then returns to run. A write with ack_data_i=0 has no effect. A supply-low reset during recovery does not clear the flag.
- R10: A stop_req_i while an eligible enabled line is already pending does not enter stop. The controller stays in run and pulses an interrupt vector for that line. Every line is eligible for retention stop; only the timer line is eligible for deep stop.
- R11: stop_req_i is ignored during recovery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset, released synchronously upstream |
| stop_req_i | input | 1 | Processor executes a stop |
| deep_sel_i | input | 1 | 1 selects deep stop, 0 selects retention stop |
| rst_pin_i | input | 1 | External reset pin asserted (active high) |
| lvd_i | input | 1 | Supply below the low-voltage trip point |
| irq_i | input | NUM_SRC | Per-source interrupt pending lines |
| irq_en_i | input | NUM_SRC | Per-source interrupt enables |
| ack_wr_i | input | 1 | Write strobe of the acknowledge bit |
| ack_data_i | input | 1 | Data written to the acknowledge bit |
| reg_mode_o | output | 2 | Regulator state: 00 full, 01 standby, 10 off |
| sys_rst_o | output | 1 | Core system reset |
| domain_rst_o | output | 1 | Reset of the domains powered down in deep stop |
| rtc_rst_o | output | 1 | Reset of the always-on timer domain |
| io_hold_o | output | 1 | Pin hold latch enable |
| wake_flag_o | output | 1 | Sticky woke-from-deep-stop status |
| vec_take_o | output | 1 | One-cycle pulse: a vector is to be taken |
| vec_is_reset_o | output | 1 | The vector is the reset vector |
| vec_src_o | output | SRC_W | Interrupt source index of the vector |

## Verification
Some properties are checked on every cycle. A supply-low input must lead to reset, and the status flag must stay set until a one is acknowledged. The pin hold must be closed whenever the flag is set. Unrelated lines must not disturb deep stop, and the timer reset must stay low in deep stop. Retention stop must never reset or hold. A reset vector must only follow a system reset. Some behaviours need the bench's sequences instead: the priority between pending sources, immediate wake on a pending line, stop requests ignored during recovery, acknowledge writes of zero, and the exact cycle at which each exit reports its vector.

// File: rtl/pwr_stop_pkg.sv
`timescale 1ns/1ps
package pwr_stop_pkg;

  typedef enum logic [2:0] {
    ST_RUN   = 3'd0,
    ST_RET   = 3'd1,
    ST_DEEP  = 3'd2,
    ST_WRST  = 3'd3,
    ST_RECOV = 3'd4
  } pwr_state_e;

  typedef enum logic [1:0] {
    REG_FULL = 2'b00,
    REG_STBY = 2'b01,
    REG_OFF  = 2'b10
  } reg_mode_e;

endpackage

// File: rtl/pwr_wake_arb.sv
`timescale 1ns/1ps
// Fixed-priority pick of the lowest-index pending wake source.
module pwr_wake_arb #(
  parameter int N = 5,
  parameter int W = 3
) (
  input  logic [N-1:0] req_i,
  output logic         any_o,
  output logic [W-1:0] idx_o
);

  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = W'(i);
    end
  end

  assign any_o = |req_i;

endmodule

// File: rtl/pwr_recov_flag.sv
`timescale 1ns/1ps
// Sticky deep-stop recovery flag; only power-on reset or an explicit clear drops it.
module pwr_recov_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);

  logic flag_d;
  logic flag_en;

  assign flag_en = set_i | clr_i;
  assign flag_d  = set_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_o <= 1'b0;
    end else if (flag_en) begin
      flag_o <= flag_d;
    end
  end

endmodule

// File: rtl/pwr_stop_ctrl.sv
`timescale 1ns/1ps
module pwr_stop_ctrl
  import pwr_stop_pkg::*;
#(
  parameter  int NUM_SRC = 5,
  parameter  int RTC_IDX = 0,
  localparam int SRC_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               stop_req_i,
  input  logic               deep_sel_i,
  input  logic               rst_pin_i,
  input  logic               lvd_i,
  input  logic [NUM_SRC-1:0] irq_i,
  input  logic [NUM_SRC-1:0] irq_en_i,
  input  logic               ack_wr_i,
  input  logic               ack_data_i,
  output logic [1:0]         reg_mode_o,
  output logic               sys_rst_o,
  output logic               domain_rst_o,
  output logic               rtc_rst_o,
  output logic               io_hold_o,
  output logic               wake_flag_o,
  output logic               vec_take_o,
  output logic               vec_is_reset_o,
  output logic [SRC_W-1:0]   vec_src_o
);

  pwr_state_e         state_q, state_d;
  logic [NUM_SRC-1:0] pend;
  logic               any_pend;
  logic [SRC_W-1:0]   pend_idx;
  logic               deep_pend;
  logic               hard_rst;
  logic               ack_one;
  logic               flag_q, flag_set, flag_clr;
  logic               vt_d, vr_d, vt_q, vr_q;
  logic [SRC_W-1:0]   vs_d, vs_q;
  logic               rtc_rst_q;

  assign pend      = irq_i & irq_en_i;
  assign deep_pend = pend[RTC_IDX];
  assign hard_rst  = rst_pin_i | lvd_i;
  assign ack_one   = ack_wr_i & ack_data_i;

  pwr_wake_arb #(.N(NUM_SRC), .W(SRC_W)) u_arb (
    .req_i (pend),
    .any_o (any_pend),
    .idx_o (pend_idx)
  );

  // Next-state and vector decision
  always_comb begin
    state_d = state_q;
    vt_d    = 1'b0;
    vr_d    = 1'b0;
    vs_d    = '0;
    if (hard_rst) begin
      state_d = ST_WRST;
    end else begin
      case (state_q)
        ST_RUN: begin
          if (stop_req_i) begin
            if (deep_sel_i ? deep_pend : any_pend) begin
              vt_d = 1'b1;
              vs_d = deep_sel_i ? SRC_W'(RTC_IDX) : pend_idx;
            end else begin
              state_d = deep_sel_i ? ST_DEEP : ST_RET;
            end
          end
        end
        ST_RET: begin
          if (any_pend) begin
            state_d = ST_RUN;
            vt_d    = 1'b1;
            vs_d    = pend_idx;
          end
        end
        ST_DEEP: begin
          if (deep_pend) state_d = ST_WRST;
        end
        ST_WRST: begin
          state_d = flag_q ? ST_RECOV : ST_RUN;
          vt_d    = 1'b1;
          vr_d    = 1'b1;
        end
        ST_RECOV: begin
          if (ack_one) state_d = ST_RUN;
        end
        default: state_d = ST_WRST;
      endcase
    end
  end

  assign flag_set = (state_q == ST_DEEP) && (state_d == ST_WRST);
  assign flag_clr = (state_q == ST_RECOV) && ack_one;

  pwr_recov_flag u_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (flag_set),
    .clr_i  (flag_clr),
    .flag_o (flag_q)
  );

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_WRST;
      vt_q      <= 1'b0;
      vr_q      <= 1'b0;
      vs_q      <= '0;
      rtc_rst_q <= 1'b1;
    end else begin
      state_q   <= state_d;
      vt_q      <= vt_d;
      vr_q      <= vr_d;
      vs_q      <= vs_d;
      rtc_rst_q <= lvd_i;
    end
  end

  // Outputs decoded from state
  always_comb begin
    case (state_q)
      ST_RET:  reg_mode_o = REG_STBY;
      ST_DEEP: reg_mode_o = REG_OFF;
      default: reg_mode_o = REG_FULL;
    endcase
  end

  assign sys_rst_o      = (state_q == ST_WRST);
  assign domain_rst_o   = (state_q == ST_WRST) || (state_q == ST_DEEP);
  assign io_hold_o      = (state_q == ST_DEEP) || flag_q;
  assign wake_flag_o    = flag_q;
  assign rtc_rst_o      = rtc_rst_q;
  assign vec_take_o     = vt_q;
  assign vec_is_reset_o = vr_q;
  assign vec_src_o      = vs_q;

endmodule

// File: rtl/pwr_stop_ctrl_chk.sv
`timescale 1ns/1ps
module pwr_stop_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rst_pin_i,
  input logic       lvd_i,
  input logic       rtc_wake,
  input logic       ack_wr_i,
  input logic       ack_data_i,
  input logic [1:0] reg_mode_o,
  input logic       sys_rst_o,
  input logic       domain_rst_o,
  input logic       rtc_rst_o,
  input logic       io_hold_o,
  input logic       wake_flag_o,
  input logic       vec_take_o,
  input logic       vec_is_reset_o
);

  assert_lvd_holds_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lvd_i |=> (sys_rst_o && rtc_rst_o));

  assert_ret_no_reset_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_mode_o == 2'b01) |-> (!sys_rst_o && !domain_rst_o && !io_hold_o));

  assert_reset_vec_after_reset_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_take_o && vec_is_reset_o) |-> $past(sys_rst_o));

  assert_rtc_kept_in_deep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((reg_mode_o == 2'b10) && !lvd_i) |=> !rtc_rst_o);

  assert_deep_ignores_others_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((reg_mode_o == 2'b10) && !rst_pin_i && !lvd_i && !rtc_wake) |=> (reg_mode_o == 2'b10));

  assert_deep_exit_sets_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((reg_mode_o == 2'b10) && rst_pin_i) |=> wake_flag_o);

  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_flag_o && !(ack_wr_i && ack_data_i)) |=> wake_flag_o);

  assert_hold_with_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wake_flag_o |-> io_hold_o);

endmodule

bind pwr_stop_ctrl pwr_stop_ctrl_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .rst_pin_i      (rst_pin_i),
  .lvd_i          (lvd_i),
  .rtc_wake       (irq_i[RTC_IDX] & irq_en_i[RTC_IDX]),
  .ack_wr_i       (ack_wr_i),
  .ack_data_i     (ack_data_i),
  .reg_mode_o     (reg_mode_o),
  .sys_rst_o      (sys_rst_o),
  .domain_rst_o   (domain_rst_o),
  .rtc_rst_o      (rtc_rst_o),
  .io_hold_o      (io_hold_o),
  .wake_flag_o    (wake_flag_o),
  .vec_take_o     (vec_take_o),
  .vec_is_reset_o (vec_is_reset_o)
);

// File: tb/pwr_stop_ctrl_bench.sv
`timescale 1ns/1ps
module pwr_stop_ctrl_bench;

  logic       clk;
  logic       rst_n;
  logic       stop_req, deep_sel, rst_pin, lvd, ack_wr, ack_data;
  logic [4:0] irq, irq_en;
  logic [1:0] reg_mode;
  logic       sys_rst, dom_rst, rtc_rst, io_hold, wflag, vtake, vreset;
  logic [2:0] vsrc;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  pwr_stop_ctrl u_pwr_stop_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .stop_req_i     (stop_req),
    .deep_sel_i     (deep_sel),
    .rst_pin_i      (rst_pin),
    .lvd_i          (lvd),
    .irq_i          (irq),
    .irq_en_i       (irq_en),
    .ack_wr_i       (ack_wr),
    .ack_data_i     (ack_data),
    .reg_mode_o     (reg_mode),
    .sys_rst_o      (sys_rst),
    .domain_rst_o   (dom_rst),
    .rtc_rst_o      (rtc_rst),
    .io_hold_o      (io_hold),
    .wake_flag_o    (wflag),
    .vec_take_o     (vtake),
    .vec_is_reset_o (vreset),
    .vec_src_o      (vsrc)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  typedef struct packed {
    logic [3:0]  req;
    logic [15:0] stim;   // stop, deep, pin, lvd, irq[4:0], en[4:0], ack_wr, ack_data
    logic [11:0] expv;   // mode[1:0], sys, dom, hold, flag, vtake, vreset, src[2:0], rtc
  } row_t;

  localparam int NROW = 29;
  localparam logic [31:0] TBL [NROW] = '{
    {4'd1,  16'b0_0_0_0_00000_11111_0_0, 12'b00_0_0_0_0_1_1_000_0}, // R1 first cycle out of reset
    {4'd1,  16'b0_0_0_0_00000_11111_0_0, 12'b00_0_0_0_0_0_0_000_0}, // R1 settled run
    {4'd3,  16'b1_0_0_0_00000_11111_0_0, 12'b01_0_0_0_0_0_0_000_0}, // R3 enter retention
    {4'd4,  16'b0_0_0_0_00100_11011_0_0, 12'b01_0_0_0_0_0_0_000_0}, // R4 disabled line no wake
    {4'd4,  16'b0_0_0_0_10010_11111_0_0, 12'b00_0_0_0_0_1_0_001_0}, // R4 lowest index wins
    {4'd4,  16'b0_0_0_0_00000_11111_0_0, 12'b00_0_0_0_0_0_0_000_0}, // R4 back in run
    {4'd10, 16'b1_0_0_0_01000_11111_0_0, 12'b00_0_0_0_0_1_0_011_0}, // R10 pending blocks stop
    {4'd6,  16'b1_1_0_0_00110_11111_0_0, 12'b10_0_1_1_0_0_0_000_0}, // R6 deep entry, non-timer pending
    {4'd7,  16'b0_0_0_0_11110_11111_0_0, 12'b10_0_1_1_0_0_0_000_0}, // R7 other lines ignored
    {4'd7,  16'b0_0_0_0_00001_11110_0_0, 12'b10_0_1_1_0_0_0_000_0}, // R7 disabled timer ignored
    {4'd8,  16'b0_0_0_0_00001_11111_0_0, 12'b00_1_1_1_1_0_0_000_0}, // R8 timer wake into reset
    {4'd8,  16'b0_0_0_0_00001_11111_0_0, 12'b00_0_0_1_1_1_1_000_0}, // R8 recovery with reset vector
    {4'd9,  16'b0_0_0_0_00000_11111_1_0, 12'b00_0_0_1_1_0_0_000_0}, // R9 write of zero
    {4'd11, 16'b1_0_0_0_00000_11111_0_0, 12'b00_0_0_1_1_0_0_000_0}, // R11 stop ignored
    {4'd9,  16'b0_0_0_0_00000_11111_1_1, 12'b00_0_0_0_0_0_0_000_0}, // R9 acknowledge releases
    {4'd5,  16'b1_0_0_0_00000_11111_0_0, 12'b01_0_0_0_0_0_0_000_0}, // R5 enter retention
    {4'd5,  16'b0_0_1_0_00000_11111_0_0, 12'b00_1_1_0_0_0_0_000_0}, // R5 pin reset
    {4'd5,  16'b0_0_1_0_00000_11111_0_0, 12'b00_1_1_0_0_0_0_000_0}, // R5 pin held
    {4'd5,  16'b0_0_0_0_00000_11111_0_0, 12'b00_0_0_0_0_1_1_000_0}, // R5 reset vector
    {4'd2,  16'b0_0_0_1_00000_11111_0_0, 12'b00_1_1_0_0_0_0_000_1}, // R2 supply low
    {4'd2,  16'b0_0_0_0_00000_11111_0_0, 12'b00_0_0_0_0_1_1_000_0}, // R2 supply back
    {4'd6,  16'b1_1_0_0_00000_11111_0_0, 12'b10_0_1_1_0_0_0_000_0}, // R6 deep entry
    {4'd8,  16'b0_0_1_0_00000_11111_0_0, 12'b00_1_1_1_1_0_0_000_0}, // R8 pin wake, timer kept
    {4'd8,  16'b0_0_0_0_00000_11111_0_0, 12'b00_0_0_1_1_1_1_000_0}, // R8 recovery
    {4'd9,  16'b0_0_0_1_00000_11111_0_0, 12'b00_1_1_1_1_0_0_000_1}, // R9 flag survives supply low
    {4'd9,  16'b0_0_0_0_00000_11111_0_0, 12'b00_0_0_1_1_1_1_000_0}, // R9 back to recovery
    {4'd9,  16'b0_0_0_0_00000_11111_1_1, 12'b00_0_0_0_0_0_0_000_0}, // R9 acknowledge
    {4'd10, 16'b1_1_0_0_00001_11111_0_0, 12'b00_0_0_0_0_1_0_000_0}, // R10 timer pending blocks deep
    {4'd10, 16'b0_0_0_0_00000_11111_0_0, 12'b00_0_0_0_0_0_0_000_0}  // R10 still in run
  };

  function automatic logic [11:0] outs();
    return {reg_mode, sys_rst, dom_rst, io_hold, wflag, vtake, vreset, vsrc, rtc_rst};
  endfunction

  task automatic check(input string tag, input logic [11:0] exp_v);
    logic [11:0] act;
    act = outs();
    n_chk++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL %s: outputs %b expected %b", tag, act, exp_v);
    end
  endtask

  task automatic drive(input logic [15:0] s);
    {stop_req, deep_sel, rst_pin, lvd, irq, irq_en, ack_wr, ack_data} = s;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run hung, expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    drive(16'b0_0_0_0_00000_11111_0_0);
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset state", 12'b00_1_1_0_0_0_0_000_1);
    rst_n = 1'b1;

    for (int i = 0; i < NROW; i++) begin
      row_t r;
      r = row_t'(TBL[i]);
      drive(r.stim);
      @(negedge clk);
      check($sformatf("R%0d row %0d", r.req, i), r.expv);
    end

    // R1 reset asserted during recovery clears the flag
    drive(16'b1_1_0_0_00000_11111_0_0);
    @(negedge clk);
    drive(16'b0_0_1_0_00000_11111_0_0);
    @(negedge clk);
    drive(16'b0_0_0_0_00000_11111_0_0);
    @(negedge clk);
    check("R8 recovery before power-on reset", 12'b00_0_0_1_1_1_1_000_0);
    rst_n = 1'b0;
    #1;
    check("R1 async reset in recovery", 12'b00_1_1_0_0_0_0_000_1);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 release to run with reset vector", 12'b00_0_0_0_0_1_1_000_0);
    @(negedge clk);
    check("R1 run after release", 12'b00_0_0_0_0_0_0_000_0);

    // R4 keyboard-only wake reports the highest index
    drive(16'b1_0_0_0_00000_11111_0_0);
    @(negedge clk);
    drive(16'b0_0_0_0_10000_11111_0_0);
    @(negedge clk);
    check("R4 keyboard wake", 12'b00_0_0_0_0_1_0_100_0);

    finish_run();
  end

endmodule